// File: doc/BRIEF.md
# Two-Stage Countdown Watchdog

This block is a countdown watchdog behind a small register file on a simple 32-bit read/write bus with byte strobes. Software programs a timeout value, writes the reload word to copy that value into the counter, and runs or halts the countdown with a control bit. A single-cycle tick enable decrements the counter. When the counter expires, the block sets a timeout flag and reloads the counter from the timeout value, so a second countdown begins at once.

If the counter expires again while software has not yet cleared the first timeout flag, the block raises a second-timeout flag. When the no-reboot strap input is low, that second expiry also sets a boot-status flag and pulses the system action output for one clock cycle. Two mailbox bytes, one for incoming and one for outgoing data, each raise a software interrupt status flag when written. The block also has a control lock bit that software can set but cannot clear. All status flags clear when software writes a one to them.

Top module: `dual_expiry_watchdog`

## Requirements
- R1: After reset, the reads are: word 0x00 = 0, word 0x04 = 0, word 0x08 = 0, word 0x0C = 0x0008_0000 (second control field is 0x0008), and word 0x10 = 0x0003_0004 (interrupt generation byte [23:16] = 0x03, timeout field [15:0] = 4).
- R2: The timeout field is word 0x10 bits [15:0]. The block keeps only its low 10 bits, so writing 0xFFFF reads back as 0x03FF. The interrupt generation byte in the same word does not change.
- R3: A write with any strobe to word 0x00 loads the counter from the timeout field. Word 0x00 bits [9:0] read the current counter value, which goes down by one on each tick while the counter is running.
- R4: While the halt bit (word 0x0C bit 11) is set, ticks leave the counter unchanged. Clearing the bit lets the countdown resume from the held value.
- R5: A tick that finds the counter at 1 (or 0) is an expiry. The expiry sets the timeout flag (word 0x08 bit 3) and reloads the counter from the timeout field. With timeout 0x3FF, after 1022 ticks the counter reads 1 and the flag is clear. The next tick sets the flag.
- R6: Every status flag clears only when a one is written to its bit with that byte strobe set. Writing zeros leaves the flags unchanged.
- R7: An expiry that occurs while the timeout flag is already set sets the second-timeout flag (word 0x08 bit 17).
- R8: On such a second expiry with no_reboot_i low, the block also sets the boot-status flag (word 0x08 bit 18) and drives action_o high for exactly one cycle. With no_reboot_i high, it does neither.
- R9: The lock bit (word 0x0C bit 12) is set by writing a one. Later writes of zero do not clear it.
- R10: A write to the data-in byte (word 0x04 [7:0]) stores the value and sets status bit 1. A write to the data-out byte (word 0x04 [15:8]) stores the value and sets status bit 2.
- R11: Without a tick pulse, the counter holds its value for any number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Single-cycle countdown enable |
| no_reboot_i | input | 1 | Strap; high suppresses the second-stage action |
| bus_addr_i | input | 5 | Byte address; bits [4:2] select the word |
| bus_we_i | input | 1 | Write enable |
| bus_be_i | input | 4 | Byte strobes for writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word (combinational) |
| action_o | output | 1 | One-cycle system action pulse on an allowed second expiry |

## Verification
The hardest state to reach from the ports is the boundary one tick before expiry at the largest timeout. Here the counter must read 1 with no flag set, and the single next tick must both raise the flag and reload the full value. The stimulus halts the counter, programs the timeout with an over-wide value, reloads, resumes, and then issues exactly 1022 tick pulses before checking and stepping once more. The second stage is reached by deliberately leaving the first flag set across a short reload. The bench runs this once with the strap high and once with it low, so that the action pulse and the boot flag are compared between the two cases.

// File: rtl/dxw_pkg.sv
// Shared constants for the two-stage watchdog: word map, bit positions,
// reset defaults. Assumes a 32-bit data bus with four byte strobes.
package dxw_pkg;
    localparam int DATA_W    = 32;
    localparam int BE_W      = DATA_W / 8;
    localparam int CNT_W_DEF = 10;

    typedef logic [2:0] word_t;
    localparam word_t W_RELOAD = 3'd0;
    localparam word_t W_MAIL   = 3'd1;
    localparam word_t W_STAT   = 3'd2;
    localparam word_t W_CTRL   = 3'd3;
    localparam word_t W_TMO    = 3'd4;

    localparam int ST1_DIN    = 1;
    localparam int ST1_DOUT   = 2;
    localparam int ST1_TMO    = 3;
    localparam int ST2_SECOND = 1;
    localparam int ST2_BOOT   = 2;
    localparam int CT1_HALT   = 11;
    localparam int CT1_LOCK   = 12;

    localparam logic [15:0] CTRL2_RST  = 16'h0008;
    localparam logic [7:0]  IRQGEN_RST = 8'h03;
    localparam int          TMO_RST    = 4;
endpackage

// File: rtl/dxw_countdown.sv
// Countdown counter. Decrements on a tick while running and flags an expiry
// when a tick finds it at 1 or 0, reloading from the timeout value at that
// moment. A load request takes priority over a tick in the same cycle.
module dxw_countdown #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] reload_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    logic             step;

    // Qualify the tick: running and not overridden by a load
    assign step     = tick_i && run_i && !load_i;
    assign expire_o = step && (cnt_q <= ONE);
    assign cnt_o    = cnt_q;

    // Counter register: load, reload on expiry, or decrement
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i || expire_o)
            cnt_q <= reload_val_i;
        else if (step)
            cnt_q <= cnt_q - ONE;
    end

    a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !load_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
    a_r4_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));
    a_r11_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dxw_escalate.sv
// Two-stage escalation. The first expiry sets the timeout flag. An expiry
// seen while that flag is set raises the second-timeout flag and, when the
// strap allows, the boot flag and a one-cycle action pulse. A set beats a
// same-cycle write-one-to-clear.
module dxw_escalate (
    input  logic clk,
    input  logic rst_n,
    input  logic expire_i,
    input  logic no_reboot_i,
    input  logic clr_tmo_i,
    input  logic clr_second_i,
    input  logic clr_boot_i,
    output logic tmo_o,
    output logic second_o,
    output logic boot_o,
    output logic action_o
);
    logic tmo_q, second_q, boot_q, act_q;

    // First-stage timeout flag
    always_ff @(posedge clk) begin
        if (!rst_n)        tmo_q <= 1'b0;
        else if (expire_i) tmo_q <= 1'b1;
        else if (clr_tmo_i) tmo_q <= 1'b0;
    end

    // Second-stage flags and action pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            second_q <= 1'b0;
            boot_q   <= 1'b0;
            act_q    <= 1'b0;
        end else begin
            act_q <= 1'b0;
            if (expire_i && tmo_q) begin
                second_q <= 1'b1;
                if (!no_reboot_i) begin
                    boot_q <= 1'b1;
                    act_q  <= 1'b1;
                end else if (clr_boot_i) begin
                    boot_q <= 1'b0;
                end
            end else begin
                if (clr_second_i) second_q <= 1'b0;
                if (clr_boot_i)   boot_q   <= 1'b0;
            end
        end
    end

    assign tmo_o    = tmo_q;
    assign second_o = second_q;
    assign boot_o   = boot_q;
    assign action_o = act_q;

    a_r7_second_needs_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_q) |-> $past(tmo_q));
    a_r8_action_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> ($past(!no_reboot_i) && boot_q && second_q));
    a_r5_expiry_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> tmo_q);
endmodule

// File: rtl/dxw_regfile.sv
// Software-visible storage: mailbox bytes and their flags, control bits with
// a sticky lock, second control field, timeout value (masked to the counter
// width) and interrupt generation byte. Also decodes reload and
// write-one-to-clear requests for the status word.
module dxw_regfile
    import dxw_pkg::*;
#(
    parameter int CNT_W = CNT_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  word_t             wr_word_i,
    input  logic [BE_W-1:0]   wr_be_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [7:0]        din_o,
    output logic [7:0]        dout_o,
    output logic              din_flag_o,
    output logic              dout_flag_o,
    output logic              halt_o,
    output logic              lock_o,
    output logic [15:0]       ctrl2_o,
    output logic [CNT_W-1:0]  tmo_val_o,
    output logic [7:0]        irqgen_o,
    output logic              load_o,
    output logic [15:0]       w1c_st1_o,
    output logic [15:0]       w1c_st2_o
);
    logic [BE_W-1:0]   wb_mail, wb_stat, wb_ctrl, wb_tmo;
    logic [DATA_W-1:0] bytemask;
    logic [15:0]       tmo_merged;
    logic              din_wr, dout_wr;

    // Per-word byte strobes
    assign wb_mail = (wr_en_i && wr_word_i == W_MAIL) ? wr_be_i : '0;
    assign wb_stat = (wr_en_i && wr_word_i == W_STAT) ? wr_be_i : '0;
    assign wb_ctrl = (wr_en_i && wr_word_i == W_CTRL) ? wr_be_i : '0;
    assign wb_tmo  = (wr_en_i && wr_word_i == W_TMO)  ? wr_be_i : '0;
    assign load_o  = wr_en_i && (wr_word_i == W_RELOAD) && (|wr_be_i);

    // Expand strobes to a bit mask
    generate
        for (genvar b = 0; b < BE_W; b++) begin : g_mask
            assign bytemask[8*b +: 8] = {8{wr_be_i[b]}};
        end
    endgenerate

    // Write-one-to-clear requests, gated by strobes
    assign w1c_st1_o = (wr_en_i && wr_word_i == W_STAT) ? (wr_data_i[15:0]  & bytemask[15:0])  : '0;
    assign w1c_st2_o = (wr_en_i && wr_word_i == W_STAT) ? (wr_data_i[31:16] & bytemask[31:16]) : '0;

    assign din_wr  = wb_mail[0];
    assign dout_wr = wb_mail[1];

    // Merge a timeout write with the current value, then mask to the counter width
    assign tmo_merged = (16'(tmo_val_o) & ~bytemask[15:0]) | (wr_data_i[15:0] & bytemask[15:0]);

    // Mailbox bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_o  <= '0;
            dout_o <= '0;
        end else begin
            if (din_wr)  din_o  <= wr_data_i[7:0];
            if (dout_wr) dout_o <= wr_data_i[15:8];
        end
    end

    // Mailbox interrupt flags: set on write, cleared by writing one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_flag_o  <= 1'b0;
            dout_flag_o <= 1'b0;
        end else begin
            if (din_wr)                   din_flag_o  <= 1'b1;
            else if (w1c_st1_o[ST1_DIN])  din_flag_o  <= 1'b0;
            if (dout_wr)                  dout_flag_o <= 1'b1;
            else if (w1c_st1_o[ST1_DOUT]) dout_flag_o <= 1'b0;
        end
    end

    // Control word: halt is plain, lock only ever sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_o  <= 1'b0;
            lock_o  <= 1'b0;
            ctrl2_o <= CTRL2_RST;
        end else begin
            if (wb_ctrl[CT1_HALT/8]) halt_o <= wr_data_i[CT1_HALT];
            if (wb_ctrl[CT1_LOCK/8]) lock_o <= lock_o | wr_data_i[CT1_LOCK];
            if (wb_ctrl[2]) ctrl2_o[7:0]  <= wr_data_i[23:16];
            if (wb_ctrl[3]) ctrl2_o[15:8] <= wr_data_i[31:24];
        end
    end

    // Timeout value and interrupt generation byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmo_val_o <= CNT_W'(TMO_RST);
            irqgen_o  <= IRQGEN_RST;
        end else begin
            if (wb_tmo[0] || wb_tmo[1]) tmo_val_o <= tmo_merged[CNT_W-1:0];
            if (wb_tmo[2])              irqgen_o  <= wr_data_i[23:16];
        end
    end

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o |=> lock_o);
    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl2_o == CTRL2_RST && irqgen_o == IRQGEN_RST
                           && tmo_val_o == CNT_W'(TMO_RST) && !lock_o && !halt_o));
    a_r10_mail_flag: assert property (@(posedge clk) disable iff (!rst_n)
        din_wr |=> din_flag_o);
    a_r6_stat_write_no_side: assert property (@(posedge clk) disable iff (!rst_n)
        (|wb_stat) |=> $stable(tmo_val_o));
endmodule

// File: rtl/dual_expiry_watchdog.sv
// Top of the two-stage watchdog. Decodes the word address, routes writes to
// the register file, connects the countdown and escalation stages, and
// drives the combinational read mux. Assumes one bus access per cycle.
module dual_expiry_watchdog
    import dxw_pkg::*;
#(
    parameter int CNT_W  = CNT_W_DEF,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              no_reboot_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [BE_W-1:0]   bus_be_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              action_o
);
    localparam int WSEL_LO = $clog2(BE_W);

    word_t            word_sel;
    logic [7:0]       din, dout, irqgen;
    logic             din_flag, dout_flag, halt, lock, load, expire;
    logic [15:0]      ctrl2, w1c1, w1c2, st1, st2, ct1;
    logic [CNT_W-1:0] tmo_val, cnt;
    logic             tmo_flag, second_flag, boot_flag;

    assign word_sel = bus_addr_i[WSEL_LO +: 3];

    dxw_regfile #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(bus_we_i), .wr_word_i(word_sel),
        .wr_be_i(bus_be_i), .wr_data_i(bus_wdata_i),
        .din_o(din), .dout_o(dout),
        .din_flag_o(din_flag), .dout_flag_o(dout_flag),
        .halt_o(halt), .lock_o(lock), .ctrl2_o(ctrl2),
        .tmo_val_o(tmo_val), .irqgen_o(irqgen),
        .load_o(load), .w1c_st1_o(w1c1), .w1c_st2_o(w1c2)
    );

    dxw_countdown #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n),
        .tick_i(tick_i), .run_i(!halt), .load_i(load),
        .reload_val_i(tmo_val), .cnt_o(cnt), .expire_o(expire)
    );

    dxw_escalate u_esc (
        .clk(clk), .rst_n(rst_n),
        .expire_i(expire), .no_reboot_i(no_reboot_i),
        .clr_tmo_i(w1c1[ST1_TMO]),
        .clr_second_i(w1c2[ST2_SECOND]),
        .clr_boot_i(w1c2[ST2_BOOT]),
        .tmo_o(tmo_flag), .second_o(second_flag),
        .boot_o(boot_flag), .action_o(action_o)
    );

    // Assemble status and control halves
    always_comb begin
        st1 = '0;
        st1[ST1_DIN]  = din_flag;
        st1[ST1_DOUT] = dout_flag;
        st1[ST1_TMO]  = tmo_flag;
        st2 = '0;
        st2[ST2_SECOND] = second_flag;
        st2[ST2_BOOT]   = boot_flag;
        ct1 = '0;
        ct1[CT1_HALT] = halt;
        ct1[CT1_LOCK] = lock;
    end

    // Read mux by word
    always_comb begin
        unique case (word_sel)
            W_RELOAD: bus_rdata_o = DATA_W'(cnt);
            W_MAIL:   bus_rdata_o = {16'h0, dout, din};
            W_STAT:   bus_rdata_o = {st2, st1};
            W_CTRL:   bus_rdata_o = {ctrl2, ct1};
            W_TMO:    bus_rdata_o = {8'h0, irqgen, 16'(tmo_val)};
            default:  bus_rdata_o = '0;
        endcase
    end

    a_r2_tmo_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we_i && word_sel == W_TMO && bus_be_i[1:0] == 2'b11)
        |=> (tmo_val == $past(bus_wdata_i[CNT_W-1:0])));
    a_r5_reload_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt == $past(tmo_val)));
endmodule

// File: tb/dual_expiry_watchdog_test.sv
module dual_expiry_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b0;
    logic        no_reboot_i = 1'b1;
    logic [4:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [3:0]  bus_be_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        action_o;

    int errors = 0;
    int checks = 0;
    int act_cnt = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_action;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    dual_expiry_watchdog uut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .no_reboot_i(no_reboot_i),
        .bus_addr_i(bus_addr_i), .bus_we_i(bus_we_i), .bus_be_i(bus_be_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .action_o(action_o)
    );

    // Monitor: counts action cycles and compares expected items as they come due
    always @(negedge clk) begin
        if (rst_n && action_o) act_cnt++;
        if (sb_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sb_q.pop_front();
            got = it.is_action ? 32'(act_cnt) : bus_rdata_o;
            checks++;
            if (got !== it.exp) begin
                errors++;
                $display("FAIL %s: got 0x%08h expected 0x%08h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] word, input logic [3:0] be, input logic [31:0] data);
        @(posedge clk); #1;
        bus_addr_i = {word, 2'b00}; bus_be_i = be; bus_wdata_i = data; bus_we_i = 1'b1;
        @(posedge clk); #1;
        bus_we_i = 1'b0; bus_be_i = '0;
    endtask

    task automatic expect_rd(input logic [2:0] word, input logic [31:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        bus_addr_i = {word, 2'b00};
        it.is_action = 1'b0; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic expect_act(input int exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        it.is_action = 1'b1; it.exp = 32'(exp); it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; tick_i = 1'b1;
            @(posedge clk); #1; tick_i = 1'b0;
        end
    endtask

    task automatic report;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset defaults
        expect_rd(3'd0, 32'h0000_0000, "R1 counter word");
        expect_rd(3'd1, 32'h0000_0000, "R1 mailbox word");
        expect_rd(3'd2, 32'h0000_0000, "R1 status word");
        expect_rd(3'd3, 32'h0008_0000, "R1 control word");
        expect_rd(3'd4, 32'h0003_0004, "R1 timeout word");

        // R2 masking to 10 bits
        wr(3'd4, 4'b0011, 32'h0000_FFFF);
        expect_rd(3'd4, 32'h0003_03FF, "R2 timeout masked");

        // R3/R4 load, halt, resume
        wr(3'd3, 4'b0010, 32'h0000_0800);
        wr(3'd4, 4'b0011, 32'h0000_0005);
        wr(3'd0, 4'b0001, 32'h0);
        expect_rd(3'd0, 32'd5, "R3 load from timeout");
        ticks(3);
        expect_rd(3'd0, 32'd5, "R4 halted counter holds");
        wr(3'd3, 4'b0010, 32'h0);
        ticks(2);
        expect_rd(3'd0, 32'd3, "R3 decrement per tick");
        repeat (20) @(posedge clk);
        expect_rd(3'd0, 32'd3, "R11 no tick no change");
        ticks(2);
        expect_rd(3'd0, 32'd1, "R5 counter at one");
        expect_rd(3'd2, 32'h0, "R5 no flag before expiry");
        ticks(1);
        expect_rd(3'd2, 32'h0000_0008, "R5 timeout flag");
        expect_rd(3'd0, 32'd5, "R5 reload after expiry");

        // R6 write-one-to-clear
        wr(3'd2, 4'b0001, 32'h0);
        expect_rd(3'd2, 32'h0000_0008, "R6 zero write keeps flag");
        wr(3'd2, 4'b0001, 32'h0000_0008);
        expect_rd(3'd2, 32'h0, "R6 one write clears flag");

        // R5 max timeout boundary
        wr(3'd3, 4'b0010, 32'h0000_0800);
        wr(3'd4, 4'b0011, 32'h0000_03FF);
        wr(3'd0, 4'b0001, 32'h0);
        wr(3'd3, 4'b0010, 32'h0);
        ticks(1022);
        expect_rd(3'd0, 32'd1, "R5 max counter reads one");
        expect_rd(3'd2, 32'h0, "R5 max no flag yet");
        ticks(1);
        expect_rd(3'd2, 32'h0000_0008, "R5 max flag on next tick");
        expect_rd(3'd0, 32'h0000_03FF, "R5 max reload");

        // R7 second expiry with strap high
        wr(3'd3, 4'b0010, 32'h0000_0800);
        wr(3'd4, 4'b0011, 32'h0000_0003);
        wr(3'd0, 4'b0001, 32'h0);
        wr(3'd3, 4'b0010, 32'h0);
        ticks(3);
        expect_rd(3'd2, 32'h0002_0008, "R7 second flag, no boot");
        expect_act(0, "R8 no action with strap high");
        wr(3'd2, 4'b1111, 32'h0006_0008);
        expect_rd(3'd2, 32'h0, "R6 clear both halves");

        // R8 second expiry with strap low
        no_reboot_i = 1'b0;
        ticks(3);
        expect_rd(3'd2, 32'h0000_0008, "R8 first stage only");
        expect_act(0, "R8 no action on first stage");
        ticks(3);
        expect_rd(3'd2, 32'h0006_0008, "R8 boot and second flags");
        expect_act(1, "R8 single action pulse");
        wr(3'd2, 4'b1111, 32'h0006_0008);
        expect_rd(3'd2, 32'h0, "R6 clear after action");
        no_reboot_i = 1'b1;

        // R9 sticky lock
        wr(3'd3, 4'b0010, 32'h0000_1000);
        expect_rd(3'd3, 32'h0008_1000, "R9 lock set");
        wr(3'd3, 4'b0010, 32'h0);
        expect_rd(3'd3, 32'h0008_1000, "R9 lock not cleared");
        wr(3'd3, 4'b0010, 32'h0000_0800);
        expect_rd(3'd3, 32'h0008_1800, "R9 lock with halt");

        // R10 mailbox flags
        wr(3'd1, 4'b0001, 32'h0000_005A);
        expect_rd(3'd1, 32'h0000_005A, "R10 data-in stored");
        expect_rd(3'd2, 32'h0000_0002, "R10 data-in flag");
        wr(3'd1, 4'b0010, 32'h0000_A500);
        expect_rd(3'd1, 32'h0000_A55A, "R10 data-out stored");
        expect_rd(3'd2, 32'h0000_0006, "R10 data-out flag");
        wr(3'd2, 4'b0001, 32'h0000_0002);
        expect_rd(3'd2, 32'h0000_0004, "R6 clear data-in flag only");

        repeat (3) @(posedge clk);
        done = 1'b1;
        report();
    end
endmodule